// File: doc/BRIEF.md
# Continuation-Stack Fibonacci Engine

This block computes the Fibonacci number of an unsigned argument without any hardware recursion. The recursive definition has been rewritten into continuation-passing form. A single register holds the pending call, and each clock cycle executes exactly one call. The call is one of two kinds. An *evaluate* call carries an argument and a pointer to a continuation record. An *apply* call carries a continuation record that has already been fetched, together with a value.

There are three kinds of continuation record:
- **terminal**: ends the computation.
- **pending-second**: remembers the original argument so that the second sub-problem can be started.
- **pending-sum**: remembers the first partial result so that it can be added to the second.

The records live in an internal memory. Because every record is read exactly once, and only after all younger records have been consumed, that memory is run as a stack. A record is released as soon as it is read.

A request enters on a valid/ready channel carrying the argument. Accepting it does two things:
- it writes a terminal record at the bottom of the stack;
- it loads an evaluate call for the argument.

The result leaves on a second valid/ready channel. The engine takes no new argument until the result has been taken.

Top module: `fib_cps_engine`

## Requirements
- R1: `in_ready` is high exactly when the engine is idle. An argument is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` and `out_valid` are never high together.
- R2: The result on `out_fib` is fib(n), with fib(1) = fib(2) = 1 and fib(k) = fib(k-1) + fib(k-2). Arithmetic is 32-bit unsigned and wraps.
- R3: An argument of 0 is processed as if it were 1, so the result is 1.
- R4: One call executes per cycle. `out_valid` first reads high 4*fib(n) - 2 clock edges after the accepting edge, counting the edge that executes the final apply-to-terminal step.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_fib` hold their values. On an edge with both high, the result is consumed, and `out_valid` is low and `in_ready` high after that edge.
- R6: `in_valid` and `in_n` are ignored while a computation is in progress. They do not change the result or the timing.
- R7: Continuation records are consumed in stack order: every read addresses the most recently written live record, and that record is freed by the read. Accepting an argument leaves exactly one live record, the terminal one.
- R8: With a stack of DEPTH records, every argument up to DEPTH+1 completes correctly without exceeding the stack. An argument n needs n-1 records at its deepest point.
- R9: After reset, `in_ready` is 1, `out_valid` is 0 and `out_fib` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Argument offered |
| in_ready | output | 1 | Engine idle and able to take an argument |
| in_n | input | 32 | Unsigned argument n |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_fib | output | 32 | fib(n), wrapping at 32 bits |

## Verification
The hardest condition to reach from the ports is a full continuation stack: the deepest descent of the evaluate chain, where the last free slot is written. The bench instantiates the stack with exactly 19 records and drives an argument of 20. That descent fills every slot before any pending-second or pending-sum record is popped.

Stack-order freeing is never visible directly. It is checked indirectly: both the result and the exact number of cycles are compared against a closed-form count of calls. Any lost or misordered record would change one or the other.

// File: rtl/fib_cps_pkg.sv
package fib_cps_pkg;

    localparam int VAL_W = 32;

    // Kind of a stored continuation record.
    typedef enum logic [1:0] {
        CT_TERM        = 2'd0,   // final continuation: deliver the value
        CT_PEND_SECOND = 2'd1,   // holds n: start evaluating n-2 next
        CT_PEND_SUM    = 2'd2    // holds first partial sum: add to value
    } cont_tag_e;

    // Kind of the call held in the call register.
    typedef enum logic {
        CALL_EVAL  = 1'b0,
        CALL_APPLY = 1'b1
    } call_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        cont_tag_e        tag;
        logic [VAL_W-1:0] val;
    } cont_rec_t;

endpackage

// File: rtl/fib_cont_stack.sv
module fib_cont_stack
    import fib_cps_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              init_i,
    input  logic                              push_i,
    input  logic                              pop_i,
    input  cont_rec_t                         push_rec_i,
    input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] push_link_i,
    input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rd_addr_i,
    output cont_rec_t                         rd_rec_o,
    output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rd_link_o,
    output logic [$clog2(DEPTH+1)-1:0]        sp_o
);

    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SPW = $clog2(DEPTH+1);

    cont_rec_t         rec_mem  [DEPTH];
    logic [AW-1:0]     link_mem [DEPTH];

    logic [SPW-1:0]    sp_d, sp_q;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    cont_rec_t         wr_rec;
    logic [AW-1:0]     wr_link;

    always_comb begin
        sp_d    = sp_q;
        wr_en   = 1'b0;
        wr_addr = AW'(sp_q);
        wr_rec  = push_rec_i;
        wr_link = push_link_i;
        if (init_i) begin
            // bottom slot receives the terminal record, one record live
            wr_en   = 1'b1;
            wr_addr = '0;
            wr_rec  = '{tag: CT_TERM, val: '0};
            wr_link = '0;
            sp_d    = SPW'(1);
        end else if (push_i) begin
            wr_en = 1'b1;
            sp_d  = sp_q + SPW'(1);
        end else if (pop_i) begin
            sp_d = sp_q - SPW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            rec_mem[wr_addr]  <= wr_rec;
            link_mem[wr_addr] <= wr_link;
        end
    end

    assign rd_rec_o  = rec_mem[rd_addr_i];
    assign rd_link_o = link_mem[rd_addr_i];
    assign sp_o      = sp_q;

    // R7: a read always targets the youngest live record
    assert_pop_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (sp_q != '0) && (rd_addr_i == AW'(sp_q - SPW'(1))));

    // R7: accepting an argument leaves only the terminal record live
    assert_init_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (sp_q == SPW'(1)));

    // R8: a push never lands beyond the last slot
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (sp_q < SPW'(DEPTH)));

    assert_push_pop_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));

endmodule

// File: rtl/fib_call_step.sv
module fib_call_step
    import fib_cps_pkg::*;
#(
    parameter int AW = 5
) (
    input  call_kind_e          kind_i,
    input  logic [VAL_W-1:0]    num_i,
    input  cont_tag_e           ctag_i,
    input  logic [VAL_W-1:0]    cval_i,
    input  logic [AW-1:0]       ptr_i,
    input  logic [AW-1:0]       free_slot_i,
    input  cont_rec_t           rd_rec_i,
    input  logic [AW-1:0]       rd_link_i,
    output call_kind_e          kind_o,
    output logic [VAL_W-1:0]    num_o,
    output cont_tag_e           ctag_o,
    output logic [VAL_W-1:0]    cval_o,
    output logic [AW-1:0]       ptr_o,
    output logic                push_o,
    output logic                pop_o,
    output cont_rec_t           push_rec_o,
    output logic [AW-1:0]       push_link_o,
    output logic                finish_o
);

    always_comb begin
        kind_o      = kind_i;
        num_o       = num_i;
        ctag_o      = ctag_i;
        cval_o      = cval_i;
        ptr_o       = ptr_i;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        push_rec_o  = '{tag: CT_PEND_SECOND, val: num_i};
        push_link_o = ptr_i;
        finish_o    = 1'b0;

        if (kind_i == CALL_EVAL) begin
            if (num_i <= VAL_W'(2)) begin
                // base case: fetch continuation at ptr and apply it to 1
                pop_o  = 1'b1;
                kind_o = CALL_APPLY;
                num_o  = VAL_W'(1);
                ctag_o = rd_rec_i.tag;
                cval_o = rd_rec_i.val;
                ptr_o  = rd_link_i;
            end else begin
                // remember n, descend into n-1
                push_o     = 1'b1;
                push_rec_o = '{tag: CT_PEND_SECOND, val: num_i};
                kind_o     = CALL_EVAL;
                num_o      = num_i - VAL_W'(1);
                ptr_o      = free_slot_i;
            end
        end else begin
            unique case (ctag_i)
                CT_PEND_SECOND: begin
                    // first half done: remember it, start on n-2
                    push_o     = 1'b1;
                    push_rec_o = '{tag: CT_PEND_SUM, val: num_i};
                    kind_o     = CALL_EVAL;
                    num_o      = cval_i - VAL_W'(2);
                    ptr_o      = free_slot_i;
                end
                CT_PEND_SUM: begin
                    pop_o  = 1'b1;
                    kind_o = CALL_APPLY;
                    num_o  = cval_i + num_i;
                    ctag_o = rd_rec_i.tag;
                    cval_o = rd_rec_i.val;
                    ptr_o  = rd_link_i;
                end
                default: begin
                    finish_o = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/fib_cps_engine.sv
module fib_cps_engine
    import fib_cps_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_n,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_fib
);

    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SPW = $clog2(DEPTH+1);
    localparam logic [VAL_W-1:0] ARG_LIMIT = VAL_W'(DEPTH + 1);

    typedef struct packed {
        phase_e           phase;
        call_kind_e       kind;
        logic [VAL_W-1:0] num;
        cont_tag_e        ctag;
        logic [VAL_W-1:0] cval;
        logic [AW-1:0]    ptr;
        logic [VAL_W-1:0] result;
    } eng_t;

    eng_t state_d, state_q;

    call_kind_e       st_kind;
    logic [VAL_W-1:0] st_num, st_cval;
    cont_tag_e        st_ctag;
    logic [AW-1:0]    st_ptr, st_push_link, rd_link;
    logic             st_push, st_pop, st_finish;
    cont_rec_t        st_push_rec, rd_rec;
    logic [SPW-1:0]   sp;
    logic             run, init_en;

    assign run = (state_q.phase == PH_RUN);

    fib_call_step #(.AW(AW)) u_step (
        .kind_i      (state_q.kind),
        .num_i       (state_q.num),
        .ctag_i      (state_q.ctag),
        .cval_i      (state_q.cval),
        .ptr_i       (state_q.ptr),
        .free_slot_i (AW'(sp)),
        .rd_rec_i    (rd_rec),
        .rd_link_i   (rd_link),
        .kind_o      (st_kind),
        .num_o       (st_num),
        .ctag_o      (st_ctag),
        .cval_o      (st_cval),
        .ptr_o       (st_ptr),
        .push_o      (st_push),
        .pop_o       (st_pop),
        .push_rec_o  (st_push_rec),
        .push_link_o (st_push_link),
        .finish_o    (st_finish)
    );

    fib_cont_stack #(.DEPTH(DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_en),
        .push_i      (run && st_push),
        .pop_i       (run && st_pop),
        .push_rec_i  (st_push_rec),
        .push_link_i (st_push_link),
        .rd_addr_i   (state_q.ptr),
        .rd_rec_o    (rd_rec),
        .rd_link_o   (rd_link),
        .sp_o        (sp)
    );

    always_comb begin
        state_d = state_q;
        init_en = 1'b0;
        unique case (state_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    init_en       = 1'b1;
                    state_d.phase = PH_RUN;
                    state_d.kind  = CALL_EVAL;
                    state_d.num   = (in_n == '0) ? VAL_W'(1) : in_n;
                    state_d.ptr   = '0;
                end
            end
            PH_RUN: begin
                if (st_finish) begin
                    state_d.phase  = PH_DONE;
                    state_d.result = state_q.num;
                end else begin
                    state_d.kind = st_kind;
                    state_d.num  = st_num;
                    state_d.ctag = st_ctag;
                    state_d.cval = st_cval;
                    state_d.ptr  = st_ptr;
                end
            end
            PH_DONE: begin
                if (out_ready) state_d.phase = PH_IDLE;
            end
            default: state_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign in_ready  = (state_q.phase == PH_IDLE);
    assign out_valid = (state_q.phase == PH_DONE);
    assign out_fib   = state_q.result;

    assert_excl_handshake_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_hold_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_fib)));

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && in_ready));

    assert_zero_as_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_n == '0) |=> (state_q.num == VAL_W'(1)));

    assert_arg_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (in_n <= ARG_LIMIT));

    assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

endmodule

// File: tb/fib_cps_engine_bench.sv
module fib_cps_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 19;
    localparam int MAX_CYC    = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_n = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_fib;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fib_cps_engine #(.DEPTH(DEPTH)) u_fib_cps_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_n      (in_n),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_fib   (out_fib)
    );

    function automatic longint unsigned ref_fib(input int n);
        longint unsigned a = 1, b = 1;
        int m = (n == 0) ? 1 : n;
        for (int i = 3; i <= m; i++) begin
            longint unsigned t = (a + b) & 32'hFFFF_FFFF;
            a = b;
            b = t;
        end
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input longint unsigned act,
                         input longint unsigned exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One request: accept, compare every clock while busy, then the result.
    task automatic run_one(input int n, input bit noisy);
        longint unsigned exp_val = ref_fib(n);
        int steps = 4 * int'(exp_val) - 2;      // R4: closed-form call count
        @(negedge clk);
        check(in_ready == 1'b1, "R1 idle before accept", in_ready, 1);
        in_n = n;
        in_valid = 1'b1;
        @(posedge clk);
        for (int i = 1; i <= steps; i++) begin
            @(negedge clk);
            if (i == 1) begin
                in_valid = noisy;               // R6: stray request while busy
                in_n = 32'd3;
            end
            if (i == steps) in_valid = 1'b0;
            check(out_valid == 1'b0 && in_ready == 1'b0, "R4 busy cycle (R1/R6)",
                  {out_valid, in_ready}, 0);
        end
        @(negedge clk);
        check(out_valid == 1'b1, "R4 result on time", out_valid, 1);
        check(out_fib == exp_val[31:0], "R2 value (R7/R8 via stack)", out_fib, exp_val);
        for (int h = 0; h < 2; h++) begin
            @(negedge clk);
            check(out_valid && out_fib == exp_val[31:0], "R5 hold", out_fib, exp_val);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid && in_ready, "R5 release", {out_valid, in_ready}, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
        check(out_fib == 32'd0, "R9 reset out_fib", out_fib, 0);
        rst_n = 1'b1;

        run_one(0, 1'b0);                       // R3 zero treated as one
        for (int n = 1; n <= 20; n++)
            run_one(n, (n == 5) || (n == 12));  // R6 noise on two runs; n=20 fills R8

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=%0d", MAX_CYC, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule